// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block tells a DRAM controller when to run start-up and refresh cycles. After reset it stays silent through a power-up pause, then asks for a fixed number of dummy row-strobe cycles to initialise the memory, and then raises a ready flag. From that point it issues refresh requests at an even cadence, spaced so that all rows are covered once per retention period.

Each request is held until the controller acknowledges it on the same clock edge (a request/acknowledge transfer). The refresh flavour is chosen by an input. In counter mode the memory steps its own row counter, so no row is supplied. In addressed mode the block supplies the row and steps through every row in turn. If the controller falls behind, the owed refreshes are counted and requests continue until the backlog is cleared. A sticky flag records that the backlog counter saturated. All durations are parameters in clock cycles.

Top module: `dram_refresh_seq`

## Requirements
- R1: While `rst_n` is low, `seq_req`, `init_done` and `debt_ovf` are 0 and `req_kind` is 0. The reset is asynchronous on assertion and is released through a two-stage synchronizer.
- R2: No request is raised during the power-up pause. The first request appears `PAUSE_CYC` + 2 rising edges after `rst_n` goes high.
- R3: After the pause, exactly `INIT_CYC` initialisation requests (`req_kind` = 1) are transferred. `init_done` rises on the edge of the last transfer, and no initialisation request follows it.
- R4: Once `init_done` is high, one refresh request falls due every `INTERVAL` edges. The first one is due `INTERVAL` edges after the last initialisation transfer.
- R5: A raised request stays up until a transfer (`seq_req` and `seq_ack` both high at an edge). `req_kind` is 0 when no request is raised, 1 for initialisation, 2 for a counter-mode refresh (`mode_ras_only` = 0) and 3 for an addressed refresh (`mode_ras_only` = 1).
- R6: Refreshes that fall due before earlier ones are transferred are owed. `seq_req` stays high until every owed refresh has been transferred, one per transfer.
- R7: When a refresh falls due while the owed count is already at 2^`DEBT_W`-1 and no transfer takes place, `debt_ovf` goes to 1. It stays 1 until reset, and the owed count stays at its maximum.
- R8: In addressed mode, `req_row` shows a row counter that starts at 0 after reset, advances by one on every addressed refresh transfer, and wraps from `ROWS`-1 to 0. In counter mode, and before `init_done`, `req_row` is 0.
- R9: `init_done` stays high until the next reset.
- R10: `INTERVAL` is `RETENTION_CYC` / `ROWS`, rounded down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ras_only | input | 1 | 1 selects addressed refresh, 0 selects counter-mode refresh |
| seq_ack | input | 1 | Controller accepts the current request |
| seq_req | output | 1 | A cycle is requested |
| req_kind | output | 2 | 0 none, 1 init, 2 counter refresh, 3 addressed refresh |
| req_row | output | ROW_W | Row to refresh in addressed mode |
| init_done | output | 1 | Initialisation complete, sticky |
| debt_ovf | output | 1 | Owed-refresh counter saturated, sticky |

## Verification
Every register lies between an input and the outputs it affects. An acknowledge or a due tick therefore shows up on `seq_req`, `req_kind`, `req_row`, `init_done` and `debt_ovf` exactly one edge later. The release of reset takes two extra edges in the synchronizer before the pause counter starts. The bench drives inputs on the falling edge and advances a cycle model of the requirements on the rising edge. It compares every output on the following falling edge, which keeps each check on the cycle in which its result is due. Long stretches without acknowledges build up the owed-refresh backlog until the counter saturates, and a reset in the middle of operation checks that every output returns to its reset value.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;
  typedef enum logic [1:0] {
    PH_PAUSE = 2'd0,
    PH_INIT  = 2'd1,
    PH_RUN   = 2'd2
  } phase_t;

  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_INIT = 2'd1,
    RK_CBR  = 2'd2,
    RK_ROW  = 2'd3
  } req_kind_t;
endpackage

// File: rtl/rfsh_powerup_ctl.sv
module rfsh_powerup_ctl
  import dram_rfsh_pkg::*;
#(
  parameter int PAUSE_CYC = 40000,
  parameter int INIT_CYC  = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   xfer,
  output phase_t phase,
  output logic   init_done
);
  localparam int PAUSE_W = $clog2(PAUSE_CYC + 1);
  localparam int INIT_W  = $clog2(INIT_CYC + 1);

  phase_t              phase_q, phase_d;
  logic [PAUSE_W-1:0]  pause_q, pause_d;
  logic [INIT_W-1:0]   init_q, init_d;
  logic                done_q, done_d;

  always_comb begin
    phase_d = phase_q;
    pause_d = pause_q;
    init_d  = init_q;
    done_d  = done_q;
    case (phase_q)
      PH_PAUSE: begin
        if (pause_q == PAUSE_W'(PAUSE_CYC - 1)) phase_d = PH_INIT;
        else                                     pause_d = pause_q + 1'b1;
      end
      PH_INIT: begin
        if (xfer) begin
          if (init_q == INIT_W'(INIT_CYC - 1)) begin
            phase_d = PH_RUN;
            done_d  = 1'b1;
          end else begin
            init_d = init_q + 1'b1;
          end
        end
      end
      PH_RUN:  phase_d = PH_RUN;
      default: phase_d = PH_PAUSE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_PAUSE;
      pause_q <= '0;
      init_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      pause_q <= pause_d;
      init_q  <= init_d;
      done_q  <= done_d;
    end
  end

  assign phase     = phase_q;
  assign init_done = done_q;
endmodule

// File: rtl/rfsh_cadence_timer.sv
module rfsh_cadence_timer #(
  parameter int INTERVAL = 3125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == CNT_W'(INTERVAL - 1));

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rfsh_debt_tracker.sv
module rfsh_debt_tracker #(
  parameter int DEBT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic xfer,
  output logic pending,
  output logic overflow
);
  localparam logic [DEBT_W-1:0] DEBT_MAX = {DEBT_W{1'b1}};

  logic [DEBT_W-1:0] owed_q, owed_d;
  logic              ovf_q, ovf_d;

  always_comb begin
    owed_d = owed_q;
    ovf_d  = ovf_q;
    case ({tick, xfer})
      2'b10: begin
        if (owed_q == DEBT_MAX) ovf_d  = 1'b1;
        else                    owed_d = owed_q + 1'b1;
      end
      2'b01:   owed_d = owed_q - 1'b1;
      default: owed_d = owed_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owed_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      owed_q <= owed_d;
      ovf_q  <= ovf_d;
    end
  end

  assign pending  = (owed_q != '0);
  assign overflow = ovf_q;
endmodule

// File: rtl/rfsh_row_gen.sv
module rfsh_row_gen #(
  parameter int ROWS  = 256,
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [ROW_W-1:0] row
);
  logic [ROW_W-1:0] row_q, row_d;

  always_comb begin
    row_d = row_q;
    if (adv) begin
      if (row_q == ROW_W'(ROWS - 1)) row_d = '0;
      else                           row_d = row_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_q <= '0;
    else        row_q <= row_d;
  end

  assign row = row_q;
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_rfsh_pkg::*;
#(
  parameter int PAUSE_CYC     = 40000,
  parameter int INIT_CYC      = 8,
  parameter int ROWS          = 256,
  parameter int RETENTION_CYC = 800000,
  parameter int DEBT_W        = 4,
  localparam int ROW_W        = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_ras_only,
  input  logic             seq_ack,
  output logic             seq_req,
  output logic [1:0]       req_kind,
  output logic [ROW_W-1:0] req_row,
  output logic             init_done,
  output logic             debt_ovf
);
  localparam int INTERVAL = RETENTION_CYC / ROWS;

  logic [1:0]       rst_sync;
  logic             rst_core_n;
  phase_t           phase;
  logic             run, tick, pending, xfer;
  logic [ROW_W-1:0] row_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  assign run     = (phase == PH_RUN);
  assign seq_req = (phase == PH_INIT) || (run && pending);
  assign xfer    = seq_req && seq_ack;

  rfsh_powerup_ctl #(.PAUSE_CYC(PAUSE_CYC), .INIT_CYC(INIT_CYC)) u_pwr (
    .clk(clk), .rst_n(rst_core_n), .xfer(xfer),
    .phase(phase), .init_done(init_done)
  );

  rfsh_cadence_timer #(.INTERVAL(INTERVAL)) u_tmr (
    .clk(clk), .rst_n(rst_core_n), .run(run), .tick(tick)
  );

  rfsh_debt_tracker #(.DEBT_W(DEBT_W)) u_debt (
    .clk(clk), .rst_n(rst_core_n), .tick(tick), .xfer(xfer && run),
    .pending(pending), .overflow(debt_ovf)
  );

  rfsh_row_gen #(.ROWS(ROWS), .ROW_W(ROW_W)) u_row (
    .clk(clk), .rst_n(rst_core_n), .adv(xfer && run && mode_ras_only),
    .row(row_cnt)
  );

  always_comb begin
    if (!seq_req)           req_kind = RK_NONE;
    else if (!run)          req_kind = RK_INIT;
    else if (mode_ras_only) req_kind = RK_ROW;
    else                    req_kind = RK_CBR;
  end

  assign req_row = (run && mode_ras_only) ? row_cnt : '0;
endmodule

// File: rtl/rfsh_seq_checker.sv
module rfsh_seq_checker #(
  parameter int ROWS  = 256,
  parameter int ROW_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_ras_only,
  input logic             seq_ack,
  input logic             seq_req,
  input logic [1:0]       req_kind,
  input logic [ROW_W-1:0] req_row,
  input logic             init_done,
  input logic             debt_ovf
);
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done); // R9

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    debt_ovf |=> debt_ovf); // R7

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_req && !seq_ack) |=> seq_req); // R5

  AST_INIT_KIND_ONLY_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_req && !init_done) |-> (req_kind == 2'd1)); // R3

  AST_DONE_AFTER_INIT_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> $past(seq_req && seq_ack && req_kind == 2'd1)); // R3

  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_req && seq_ack && req_kind == 2'd3 && req_row != ROW_W'(ROWS - 1))
      |=> (!mode_ras_only || req_row == $past(req_row) + 1'b1)); // R8

  AST_CBR_NO_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (req_kind == 2'd2) |-> (req_row == '0)); // R8
endmodule

bind dram_refresh_seq rfsh_seq_checker #(.ROWS(ROWS), .ROW_W(ROW_W)) u_chk (.*);

// File: tb/dram_refresh_seq_test.sv
`timescale 1ns/1ps
module dram_refresh_seq_test;
  localparam int P_PAUSE = 20;
  localparam int P_INIT  = 8;
  localparam int P_ROWS  = 8;
  localparam int P_RET   = 100;
  localparam int P_DEBTW = 3;
  localparam int IV      = P_RET / P_ROWS;
  localparam int DMAX    = (1 << P_DEBTW) - 1;
  localparam int RW      = $clog2(P_ROWS);

  logic clk = 1'b0;
  logic rst_n, mode_ras_only, seq_ack;
  logic seq_req, init_done, debt_ovf;
  logic [1:0] req_kind;
  logic [RW-1:0] req_row;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // cycle model of the requirements
  int m_sync, m_phase, m_pause, m_init, m_tick, m_owed, m_row;
  bit m_done, m_ovf;

  always #2.5 clk = ~clk;

  dram_refresh_seq #(.PAUSE_CYC(P_PAUSE), .INIT_CYC(P_INIT), .ROWS(P_ROWS),
                     .RETENTION_CYC(P_RET), .DEBT_W(P_DEBTW)) uut (
    .clk(clk), .rst_n(rst_n), .mode_ras_only(mode_ras_only), .seq_ack(seq_ack),
    .seq_req(seq_req), .req_kind(req_kind), .req_row(req_row),
    .init_done(init_done), .debt_ovf(debt_ovf)
  );

  function automatic bit exp_req();
    return (m_sync >= 2) && (m_phase == 1 || (m_phase == 2 && m_owed != 0));
  endfunction

  function automatic int exp_kind();
    if (!exp_req()) return 0;
    if (m_phase == 1) return 1;
    return mode_ras_only ? 3 : 2;
  endfunction

  function automatic int exp_row();
    return (m_phase == 2 && mode_ras_only) ? m_row : 0;
  endfunction

  task automatic model_reset();
    m_sync = 0; m_phase = 0; m_pause = 0; m_init = 0; m_tick = 0;
    m_owed = 0; m_row = 0; m_done = 0; m_ovf = 0;
  endtask

  task automatic model_edge();
    bit xfer, tk;
    if (!rst_n) begin model_reset(); return; end
    if (m_sync < 2) begin m_sync++; return; end
    xfer = exp_req() && seq_ack;
    case (m_phase)
      0: if (m_pause == P_PAUSE - 1) m_phase = 1; else m_pause++;
      1: if (xfer) begin
           if (m_init == P_INIT - 1) begin m_phase = 2; m_done = 1; end
           else m_init++;
         end
      default: begin
        tk = (m_tick == IV - 1);
        m_tick = tk ? 0 : m_tick + 1;
        if (tk && !xfer) begin
          if (m_owed == DMAX) m_ovf = 1; else m_owed++;
        end else if (!tk && xfer) m_owed--;
        if (xfer && mode_ras_only) m_row = (m_row == P_ROWS - 1) ? 0 : m_row + 1;
      end
    endcase
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    string rtag;
    if (m_phase == 0)      rtag = "R2 pause silence";
    else if (m_phase == 1) rtag = "R3 init requests";
    else if (m_owed > 1)   rtag = "R6 owed refreshes";
    else                   rtag = "R4 R10 refresh cadence";
    check({rtag, " seq_req"}, int'(seq_req), int'(exp_req()));
    check("R5 req_kind", int'(req_kind), exp_kind());
    check("R8 req_row", int'(req_row), exp_row());
    check("R3 R9 init_done", int'(init_done), int'(m_done));
    check("R7 debt_ovf", int'(debt_ovf), int'(m_ovf));
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic step(input bit a, input bit m);
    seq_ack = a;
    mode_ras_only = m;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic run_seg(input int n, input int ack_pct, input int mode_sel);
    for (int i = 0; i < n; i++) begin
      bit m;
      if (mode_sel == 2) m = ($urandom % 8) == 0 ? ~mode_ras_only : mode_ras_only;
      else               m = mode_sel[0];
      step(($urandom % 100) < ack_pct, m);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; seq_ack = 1'b0; mode_ras_only = 1'b0;
    model_reset();
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1 reset seq_req", int'(seq_req), 0);
      check("R1 reset req_kind", int'(req_kind), 0);
      check("R1 reset init_done", int'(init_done), 0);
      check("R1 reset debt_ovf", int'(debt_ovf), 0);
    end
    rst_n = 1'b1;
    // R2: pause, then init requests held without ack
    run_seg(P_PAUSE + 10, 0, 0);
    // R3 R4 R5: init and refresh with random acks, counter mode
    run_seg(400, 50, 0);
    // R6 R7: starve the controller until the backlog saturates
    run_seg(IV * (DMAX + 3), 0, 0);
    check("R7 saturation reached", int'(debt_ovf), 1);
    // R8: addressed mode, rows wrap
    run_seg(1500, 70, 1);
    // R1 R9: reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 R9 init_done cleared by reset", int'(init_done), 0);
    check("R1 debt_ovf cleared by reset", int'(debt_ovf), 0);
    model_reset();
    step(1'b0, 1'b1);
    rst_n = 1'b1;
    run_seg(400, 100, 1);
    // mode toggling with mixed acks
    run_seg(600, 40, 2);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule